// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block produces a divided copy of the oscillator clock and places it on a general-purpose port pin as that pin's alternate function. Software controls it through two single-bit controls that sit at fixed positions in two byte-wide registers. The gate control turns the clock output on or off. The ratio control picks a division of 6 or of 12. A separate slow-down input, driven by the chip's power-mode logic, multiplies the selected division by a further 8. This gives division by 48 or by 96.

The pin only carries the clock while the port latch bit for that pin holds 1. With the gate control off, the pin simply follows the port latch. The output is symmetric: the high and low phases each last half the selected division. A new ratio or slow-down state is picked up only where one output period ends and the next begins. Turning the gate off holds the divider idle, so turning it on again always starts with a full high phase.

The divider is a three-state machine, with its transitions named below:
- `PH_OFF`: idle, counter cleared.
- `PH_HIGH`: output phase high.
- `PH_LOW`: output phase low.
- `start`: `PH_OFF`→`PH_HIGH` when the gate control is 1. This transition loads the half-period.
- `fall`: `PH_HIGH`→`PH_LOW` when the half-period count completes.
- `wrap`: `PH_LOW`→`PH_HIGH` when the half-period count completes. This transition reloads the half-period from the current controls.
- `stop`: `PH_HIGH`/`PH_LOW`→`PH_OFF` when the gate control is 0.

Top module: `clkout_divider`

## Requirements
- R1: After reset, a read of address 0xD8 returns 0x00 and a read of address 0xB1 returns 0x80. The gate control is off and the ratio control is 1.
- R2: The gate control is bit 6 of address 0xD8 and is written when `reg_we` is 1 at a clock edge. A read returns the stored bit in position 6 and 0 in every other position. Any address other than 0xD8 or 0xB1 reads as 0x00.
- R3: The ratio control is bit 7 of address 0xB1 and is written in the same way. A read returns it in position 7 and 0 elsewhere.
- R4: While the gate control is 0, `pin_out` equals `port_latch` in every cycle.
- R5: While the gate control is 1 and `port_latch` is 0, `pin_out` is 0.
- R6: With the ratio control at 0 and `slow_mode` at 0, `pin_out` is high for 3 cycles and low for 3 cycles.
- R7: With the ratio control at 1 and `slow_mode` at 0, `pin_out` is high for 6 cycles and low for 6 cycles.
- R8: With `slow_mode` at 1, each phase lasts 8 times as long: 24 cycles for ratio control 0, and 48 cycles for ratio control 1.
- R9: A change of the ratio control or of `slow_mode` during a period leaves that period's high and low phases at the old length. The new length applies from the next rising edge of the output.
- R10: Setting the gate control to 0 clears the divider. After it is set to 1 again, `pin_out` is low for one cycle and then high for a full phase.
- R11: Register bits other than the two controls, and writes to any other address, have no effect on the stored controls or on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| port_latch | input | 1 | Port latch bit of the shared pin (1 after chip reset) |
| slow_mode | input | 1 | Slow-down mode active: extra divide by 8 |
| pin_out | output | 1 | Shared pin drive |

## Verification
A divider counter or half-period that is wrong shows up at the pin within one output period, as a high or low run of the wrong length. That is at most 96 cycles, even in the slowest mode. A ratio that is reloaded at the wrong moment shows up as a shortened or stretched phase in the period during which the control changed. A machine that is not cleared by the gate control shows up as a truncated first high phase right after re-enabling. A wrong register decode shows up at once on the read port or as a pin that ignores the gate.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/clkdiv_ctrl_regs.sv
module clkdiv_ctrl_regs #(
    parameter logic [7:0] GATE_ADDR  = 8'hD8,
    parameter int         GATE_BIT   = 6,
    parameter logic [7:0] RATIO_ADDR = 8'hB1,
    parameter int         RATIO_BIT  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       gate_en,
    output logic       ratio_sel
);
    logic gate_q;
    logic ratio_q;
    logic unused_wbits;

    // only the two control bit positions are meaningful
    assign unused_wbits = ^{wdata[5:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            ratio_q <= 1'b1;
        end else if (we) begin
            if (addr == GATE_ADDR)  gate_q  <= wdata[GATE_BIT];
            if (addr == RATIO_ADDR) ratio_q <= wdata[RATIO_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == GATE_ADDR)       rdata[GATE_BIT]  = gate_q;
        else if (addr == RATIO_ADDR) rdata[RATIO_BIT] = ratio_q;
    end

    assign gate_en   = gate_q;
    assign ratio_sel = ratio_q;
endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio #(
    parameter int DIV_FAST    = 6,
    parameter int DIV_NORMAL  = 12,
    parameter int SLOW_FACTOR = 8,
    parameter int HALF_W      = 6
) (
    input  logic              ratio_sel,
    input  logic              slow_mode,
    output logic [HALF_W-1:0] half_len
);
    localparam logic [HALF_W-1:0] H_FAST      = HALF_W'(DIV_FAST / 2);
    localparam logic [HALF_W-1:0] H_NORMAL    = HALF_W'(DIV_NORMAL / 2);
    localparam logic [HALF_W-1:0] H_FAST_SLW  = HALF_W'(DIV_FAST * SLOW_FACTOR / 2);
    localparam logic [HALF_W-1:0] H_NORM_SLW  = HALF_W'(DIV_NORMAL * SLOW_FACTOR / 2);

    always_comb begin
        unique case ({slow_mode, ratio_sel})
            2'b00:   half_len = H_FAST;
            2'b01:   half_len = H_NORMAL;
            2'b10:   half_len = H_FAST_SLW;
            default: half_len = H_NORM_SLW;
        endcase
    end
endmodule

// File: rtl/clkdiv_phase_fsm.sv
module clkdiv_phase_fsm
    import clkdiv_pkg::*;
#(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] next_half,
    output logic              phase_high,
    output logic [HALF_W-1:0] half_q,
    output phase_e            state
);
    phase_e            state_q, state_d;
    logic [HALF_W-1:0] cnt_q;
    logic              last;
    logic              load;

    assign last = (cnt_q == half_q - 1'b1);
    assign load = run && ((state_q == PH_OFF) || (state_q == PH_LOW && last));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OFF:  if (run) state_d = PH_HIGH;                 // start
            PH_HIGH: if (!run) state_d = PH_OFF;                 // stop
                     else if (last) state_d = PH_LOW;            // fall
            PH_LOW:  if (!run) state_d = PH_OFF;                 // stop
                     else if (last) state_d = PH_HIGH;           // wrap
            default: state_d = PH_OFF;
        endcase
    end

    // state register, phase counter and half-period hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            cnt_q   <= '0;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == PH_OFF) cnt_q <= '0;
            else                                         cnt_q <= cnt_q + 1'b1;
            if (load) half_q <= next_half;
        end
    end

    // outputs
    always_comb begin
        phase_high = (state_q == PH_HIGH);
        state      = state_q;
    end
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
    import clkdiv_pkg::*;
#(
    parameter logic [7:0] GATE_ADDR   = 8'hD8,
    parameter int         GATE_BIT    = 6,
    parameter logic [7:0] RATIO_ADDR  = 8'hB1,
    parameter int         RATIO_BIT   = 7,
    parameter int         DIV_FAST    = 6,
    parameter int         DIV_NORMAL  = 12,
    parameter int         SLOW_FACTOR = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       port_latch,
    input  logic       slow_mode,
    output logic       pin_out
);
    localparam int MAX_HALF = DIV_NORMAL * SLOW_FACTOR / 2;
    localparam int HALF_W   = $clog2(MAX_HALF + 1);

    logic              ctl_en;
    logic              ctl_sel;
    logic [HALF_W-1:0] next_half;
    logic [HALF_W-1:0] half_q;
    logic              ph_high;
    phase_e            fsm_state;

    clkdiv_ctrl_regs #(
        .GATE_ADDR (GATE_ADDR),
        .GATE_BIT  (GATE_BIT),
        .RATIO_ADDR(RATIO_ADDR),
        .RATIO_BIT (RATIO_BIT)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .gate_en  (ctl_en),
        .ratio_sel(ctl_sel)
    );

    clkdiv_ratio #(
        .DIV_FAST   (DIV_FAST),
        .DIV_NORMAL (DIV_NORMAL),
        .SLOW_FACTOR(SLOW_FACTOR),
        .HALF_W     (HALF_W)
    ) i_ratio (
        .ratio_sel(ctl_sel),
        .slow_mode(slow_mode),
        .half_len (next_half)
    );

    clkdiv_phase_fsm #(
        .HALF_W(HALF_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_en),
        .next_half (next_half),
        .phase_high(ph_high),
        .half_q    (half_q),
        .state     (fsm_state)
    );

    assign pin_out = ctl_en ? (ph_high & port_latch) : port_latch;
endmodule

// File: rtl/clkout_divider_chk.sv
module clkout_divider_chk
    import clkdiv_pkg::*;
#(
    parameter int DIV_FAST    = 6,
    parameter int DIV_NORMAL  = 12,
    parameter int SLOW_FACTOR = 8,
    parameter int HALF_W      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              latch,
    input logic              pin,
    input logic              ph_high,
    input logic [HALF_W-1:0] half_q,
    input phase_e            state
);
    logic [HALF_W:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= '0;
        else if (ph_high) hi_run <= hi_run + 1'b1;
        else              hi_run <= '0;
    end

    assert_idle_follows_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pin == latch));

    assert_gated_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !latch) |-> !pin);

    assert_high_run_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ph_high) && $past(en)) |-> (hi_run == {1'b0, half_q}));

    assert_ratio_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_OFF) |-> (half_q == HALF_W'(DIV_FAST / 2)
                            || half_q == HALF_W'(DIV_NORMAL / 2)
                            || half_q == HALF_W'(DIV_FAST * SLOW_FACTOR / 2)
                            || half_q == HALF_W'(DIV_NORMAL * SLOW_FACTOR / 2)));

    assert_reload_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_q) |-> ($past(state) != PH_HIGH));

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == PH_OFF));
endmodule

bind clkout_divider clkout_divider_chk #(
    .DIV_FAST   (DIV_FAST),
    .DIV_NORMAL (DIV_NORMAL),
    .SLOW_FACTOR(SLOW_FACTOR),
    .HALF_W     (HALF_W)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctl_en),
    .latch  (port_latch),
    .pin    (pin_out),
    .ph_high(ph_high),
    .half_q (half_q),
    .state  (fsm_state)
);

// File: tb/test_clkout_divider.sv
`timescale 1ns/1ps
module test_clkout_divider;
    localparam logic [7:0] A_GATE  = 8'hD8;
    localparam logic [7:0] A_RATIO = 8'hB1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       port_latch = 1'b1;
    logic       slow_mode = 1'b0;
    logic       pin_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    clkout_divider i_clkout_divider (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_latch(port_latch),
        .slow_mode(slow_mode), .pin_out(pin_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic measure(input int exp_half, input string req);
        int hi, lo, guard;
        guard = 0;
        while (pin_out !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
        while (pin_out !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
        hi = 0;
        while (pin_out === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
        lo = 0;
        while (pin_out === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
        check({req, " high phase"}, hi, exp_half);
        check({req, " low phase"}, lo, exp_half);
    endtask

    task automatic t_reset_state;
        int v;
        read_reg(A_GATE, v);  check("R1 gate register after reset", v, 8'h00);
        read_reg(A_RATIO, v); check("R1 ratio register after reset", v, 8'h80);
        port_latch = 1'b0; @(negedge clk);
        check("R4 disabled pin follows latch 0", int'(pin_out), 0);
        port_latch = 1'b1; @(negedge clk);
        check("R4 disabled pin follows latch 1", int'(pin_out), 1);
    endtask

    task automatic t_enable_normal;
        int v;
        write_reg(A_GATE, 8'h40);
        read_reg(A_GATE, v); check("R2 gate bit 6 reads back", v, 8'h40);
        measure(6, "R7 ratio 12");
    endtask

    task automatic t_latch_gating;
        int ones = 0;
        port_latch = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (pin_out === 1'b1) ones++;
        end
        check("R5 latch 0 blocks clock, high samples", ones, 0);
        port_latch = 1'b1;
    endtask

    task automatic t_fast;
        int v;
        write_reg(A_RATIO, 8'h00);
        read_reg(A_RATIO, v); check("R3 ratio bit 7 reads back 0", v, 8'h00);
        measure(3, "R6 ratio 6");
    endtask

    task automatic t_slow;
        slow_mode = 1'b1;
        measure(24, "R8 slow ratio 6");
        write_reg(A_RATIO, 8'h80);
        measure(48, "R8 slow ratio 12");
        slow_mode = 1'b0;
        measure(6, "R8 slow released");
    endtask

    task automatic t_mid_period_change;
        int hi, lo, hi2, guard;
        guard = 0;
        while (pin_out !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
        while (pin_out !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
        reg_we = 1'b1; reg_addr = A_RATIO; reg_wdata = 8'h00;
        hi = 0;
        while (pin_out === 1'b1 && hi < 500) begin hi++; @(negedge clk); reg_we = 1'b0; end
        lo = 0;
        while (pin_out === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
        hi2 = 0;
        while (pin_out === 1'b1 && hi2 < 500) begin hi2++; @(negedge clk); end
        check("R9 current high phase keeps old length", hi, 6);
        check("R9 current low phase keeps old length", lo, 6);
        check("R9 next high phase uses new length", hi2, 3);
    endtask

    task automatic t_other_bits;
        int v;
        write_reg(A_GATE, 8'hBF);
        read_reg(A_GATE, v); check("R11 other gate bits ignored, gate cleared", v, 8'h00);
        write_reg(A_GATE, 8'h7F);
        read_reg(A_GATE, v); check("R11 other gate bits ignored, gate set", v, 8'h40);
        write_reg(A_RATIO, 8'h7F);
        read_reg(A_RATIO, v); check("R11 other ratio bits ignored", v, 8'h00);
        write_reg(8'h10, 8'hFF);
        read_reg(8'h10, v); check("R2 unmapped address reads 0", v, 8'h00);
        read_reg(A_GATE, v); check("R11 foreign write leaves gate", v, 8'h40);
        measure(3, "R11 output unchanged by foreign writes");
    endtask

    task automatic t_disable_reenable;
        int hi;
        write_reg(A_RATIO, 8'h80);
        measure(6, "R7 ratio 12 again");
        repeat (2) @(negedge clk);
        write_reg(A_GATE, 8'h00);
        port_latch = 1'b0; @(negedge clk);
        check("R4 after disable pin follows latch 0", int'(pin_out), 0);
        port_latch = 1'b1; @(negedge clk);
        check("R4 after disable pin follows latch 1", int'(pin_out), 1);
        write_reg(A_GATE, 8'h40);
        check("R10 one low cycle before first high", int'(pin_out), 0);
        @(negedge clk);
        hi = 0;
        while (pin_out === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
        check("R10 first high phase is full", hi, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enable_normal();
        t_latch_gating();
        t_fast();
        t_slow();
        t_mid_period_change();
        t_other_bits();
        t_disable_reenable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule